// File: doc/BRIEF.md
# Capture/Reload Timer with Baud Overflow Outputs

This block is a 16-bit timer/counter paired with a 16-bit capture/reload register and an 8-bit control/status register. It counts either an internal tick enable or falling edges of an external count pin. A falling edge on an external trigger pin can either copy the running count into the capture register or load the counter from that register. One control bit chooses which of the two happens.

The counter can also act as a baud source for a serial port. When either the receive or transmit clock enable is set, the counter always reloads on overflow. The overflow flag stays clear, and the trigger pin is ignored. Each overflow then produces a one-cycle pulse on the receive and/or transmit baud output. The period is 65536 minus the reload value, counted in ticks.

Software reaches all registers through an 8-bit address/data port. Reads are combinational and writes take effect at the clock edge. Both external pins pass through a two-flop synchroniser before edge detection. The asynchronous reset is released synchronously inside the block. The interrupt request is high while either status flag is set.

Top module: `cap_reload_timer`

## Requirements
- R1: After reset, every register reads 0x00, and `irq`, `rx_baud_pulse` and `tx_baud_pulse` are low.
- R2: Address 0 is the control register. Its bits from bit 7 down to bit 0 are: overflow flag, trigger flag, rx clock enable, tx clock enable, trigger enable, run, count-pin select, capture select. Addresses 1/2 are the count low/high bytes, and 3/4 are the capture low/high bytes; each reads back what was last written. Addresses 5 to 7 read 0x00.
- R3: With run=1 and count-pin select=0, the count rises by one at each clock edge where `tick_en` is high. With run=0 the count holds.
- R4: With count-pin select=1, the count rises by one for each falling edge on `count_pin`, and `tick_en` has no effect.
- R5: Outside baud mode, a count step from 0xFFFF goes to 0x0000 when capture select=1, or to the capture register value when capture select=0. In both cases the overflow flag is set.
- R6: Once set, the overflow flag stays set until software writes 0 to it. A flag set by hardware in the same cycle as such a write wins.
- R7: With trigger enable=1 and capture select=1, a falling edge on `trig_pin` copies the count into the capture register and sets the trigger flag.
- R8: With trigger enable=1 and capture select=0, a falling edge on `trig_pin` loads the count from the capture register and sets the trigger flag.
- R9: With trigger enable=0, a falling edge on `trig_pin` changes neither the count, the capture register, nor the trigger flag.
- R10: In baud mode (rx or tx clock enable set), overflow reloads the count from the capture register whatever capture select says. The overflow flag is not set, and trigger pin edges are ignored.
- R11: In baud mode, `rx_baud_pulse` (rx enable set) and `tx_baud_pulse` (tx enable set) are high for the one cycle after each overflow. With ticks every cycle, they repeat every 65536 minus capture-value cycles.
- R12: `irq` is high exactly while the overflow flag or the trigger flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| tick_en | input | 1 | Internal count tick |
| count_pin | input | 1 | External count input, asynchronous |
| trig_pin | input | 1 | External trigger input, asynchronous |
| irq | output | 1 | Interrupt request |
| rx_baud_pulse | output | 1 | Receive baud overflow pulse |
| tx_baud_pulse | output | 1 | Transmit baud overflow pulse |

## Verification
Counting is driven with several tick duty patterns, which separates counting on tick cycles from counting on every cycle. Counting is also driven with count-pin toggles while ticks stay on, which shows the count source really is switched. Overflow is started just below 0xFFFF in capture mode, reload mode and baud mode. This separates the wrap target from the flag behaviour. Baud periods from one to eight ticks are swept for both directions, which checks the pulse spacing and the pulse routing. Trigger edges are applied with a sweep of count values under capture, reload, disabled and baud settings, so a wrong copy direction or missing gating shows up in the register readback.

// File: rtl/crt_pkg.sv
package crt_pkg;
  typedef struct packed {
    logic ovf_flag;
    logic trg_flag;
    logic rx_clk_en;
    logic tx_clk_en;
    logic trg_en;
    logic run;
    logic pin_sel;
    logic cap_sel;
  } crt_ctrl_t;

  localparam int CTRL_ADDR = 0;
  localparam int CNT_BASE  = 1;
endpackage

// File: rtl/crt_edge_fall.sv
module crt_edge_fall #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic fall
);
  logic [STAGES-1:0] sync_q, sync_d;
  logic              last_q, last_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], pin};
    last_d = sync_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      last_q <= last_d;
    end
  end

  assign fall = last_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/crt_ctrl_reg.sv
module crt_ctrl_reg
  import crt_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_ctrl,
  input  logic [7:0] wdata,
  input  logic      set_ovf,
  input  logic      set_trg,
  output crt_ctrl_t ctrl_q
);
  crt_ctrl_t ctrl_d;
  logic      ctrl_en;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ctrl) ctrl_d = crt_ctrl_t'(wdata);
    if (set_ovf) ctrl_d.ovf_flag = 1'b1;
    if (set_trg) ctrl_d.trg_flag = 1'b1;
    ctrl_en = wr_ctrl | set_ovf | set_trg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_en) ctrl_q <= ctrl_d;
  end
endmodule

// File: rtl/crt_count_path.sv
module crt_count_path
  import crt_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  crt_ctrl_t         ctrl,
  input  logic              tick_en,
  input  logic              cnt_fall,
  input  logic              trg_fall,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [CNT_W-1:0]  cnt_q,
  output logic [CNT_W-1:0]  cap_q,
  output logic              set_ovf,
  output logic              set_trg,
  output logic              rx_pulse_q,
  output logic              tx_pulse_q
);
  localparam int NB       = CNT_W / 8;
  localparam int CAP_BASE = CNT_BASE + NB;

  logic [NB-1:0]    cnt_bwe, cap_bwe;
  logic [CNT_W-1:0] cnt_d, cap_d, cnt_hw;
  logic             baud, reload_mode, step, wrap, trg;
  logic             do_reload, do_capture, cnt_en, cap_en;
  logic             rx_pulse_d, tx_pulse_d;

  for (genvar b = 0; b < NB; b++) begin : g_bwe
    assign cnt_bwe[b] = reg_wr && (reg_addr == ADDR_W'(CNT_BASE + b));
    assign cap_bwe[b] = reg_wr && (reg_addr == ADDR_W'(CAP_BASE + b));
  end

  always_comb begin
    baud        = ctrl.rx_clk_en | ctrl.tx_clk_en;
    reload_mode = baud | ~ctrl.cap_sel;
    step        = ctrl.run & (ctrl.pin_sel ? cnt_fall : tick_en);
    wrap        = step & (&cnt_q);
    trg         = ctrl.trg_en & ~baud & trg_fall;
    do_reload   = reload_mode & (wrap | trg);
    do_capture  = trg & ctrl.cap_sel;
    set_ovf     = wrap & ~baud;
    set_trg     = trg;
    rx_pulse_d  = wrap & ctrl.rx_clk_en;
    tx_pulse_d  = wrap & ctrl.tx_clk_en;

    if (do_reload)  cnt_hw = cap_q;
    else if (step)  cnt_hw = cnt_q + 1'b1;
    else            cnt_hw = cnt_q;

    cnt_d = cnt_hw;
    cap_d = cap_q;
    for (int b = 0; b < NB; b++) begin
      if (cnt_bwe[b]) cnt_d[8*b +: 8] = reg_wdata;
      if (cap_bwe[b]) cap_d[8*b +: 8] = reg_wdata;
    end
    if (do_capture) cap_d = cnt_q;

    cnt_en = step | do_reload | (|cnt_bwe);
    cap_en = do_capture | (|cap_bwe);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cap_q <= '0;
    else if (cap_en) cap_q <= cap_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_pulse_q <= 1'b0;
      tx_pulse_q <= 1'b0;
    end else begin
      rx_pulse_q <= rx_pulse_d;
      tx_pulse_q <= tx_pulse_d;
    end
  end
endmodule

// File: rtl/cap_reload_timer.sv
module cap_reload_timer
  import crt_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              tick_en,
  input  logic              count_pin,
  input  logic              trig_pin,
  output logic              irq,
  output logic              rx_baud_pulse,
  output logic              tx_baud_pulse
);
  localparam int NB       = CNT_W / 8;
  localparam int CAP_BASE = CNT_BASE + NB;

  logic [1:0]       rst_pipe_q;
  logic             rst_sync_n;
  logic             cnt_fall, trg_fall, set_ovf, set_trg, wr_ctrl;
  logic [CNT_W-1:0] cnt_q, cap_q;
  crt_ctrl_t        ctrl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  crt_edge_fall #(.STAGES(SYNC_STAGES)) u_cnt_edge (
    .clk(clk), .rst_n(rst_sync_n), .pin(count_pin), .fall(cnt_fall)
  );

  crt_edge_fall #(.STAGES(SYNC_STAGES)) u_trg_edge (
    .clk(clk), .rst_n(rst_sync_n), .pin(trig_pin), .fall(trg_fall)
  );

  assign wr_ctrl = reg_wr && (reg_addr == ADDR_W'(CTRL_ADDR));

  crt_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_sync_n), .wr_ctrl(wr_ctrl), .wdata(reg_wdata),
    .set_ovf(set_ovf), .set_trg(set_trg), .ctrl_q(ctrl_q)
  );

  crt_count_path #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_path (
    .clk(clk), .rst_n(rst_sync_n), .ctrl(ctrl_q), .tick_en(tick_en),
    .cnt_fall(cnt_fall), .trg_fall(trg_fall), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .cnt_q(cnt_q), .cap_q(cap_q),
    .set_ovf(set_ovf), .set_trg(set_trg),
    .rx_pulse_q(rx_baud_pulse), .tx_pulse_q(tx_baud_pulse)
  );

  always_comb begin
    reg_rdata = 8'h00;
    if (reg_addr == ADDR_W'(CTRL_ADDR)) reg_rdata = ctrl_q;
    for (int b = 0; b < NB; b++) begin
      if (reg_addr == ADDR_W'(CNT_BASE + b)) reg_rdata = cnt_q[8*b +: 8];
      if (reg_addr == ADDR_W'(CAP_BASE + b)) reg_rdata = cap_q[8*b +: 8];
    end
  end

  assign irq = ctrl_q.ovf_flag | ctrl_q.trg_flag;
endmodule

// File: rtl/crt_checker.sv
module crt_checker #(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [7:0]        ctrl,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  cap,
  input logic              irq,
  input logic              rx_pulse,
  input logic              tx_pulse
);
  logic wr_ctrl;
  assign wr_ctrl = reg_wr && (reg_addr == '0);

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl[7] && !wr_ctrl |=> ctrl[7]); // R6
  AST_BAUD_NO_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[5] || ctrl[4]) && !ctrl[7] && !wr_ctrl |=> !ctrl[7]); // R10
  AST_TRG_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl[3] && !ctrl[6] && !wr_ctrl |=> !ctrl[6]); // R9
  AST_PULSE_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pulse || tx_pulse) && !$past(reg_wr) |-> cnt == cap); // R10
  AST_RX_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pulse |-> $past(ctrl[5])); // R11
  AST_TX_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pulse |-> $past(ctrl[4])); // R11
  AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl[2] && !ctrl[3] && !reg_wr |=> $stable(cnt)); // R3
  AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !wr_ctrl |=> irq); // R12
endmodule

bind cap_reload_timer crt_checker #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_crt_checker (
  .clk(clk), .rst_n(rst_sync_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .ctrl(ctrl_q), .cnt(cnt_q), .cap(cap_q), .irq(irq),
  .rx_pulse(rx_baud_pulse), .tx_pulse(tx_baud_pulse)
);

// File: tb/cap_reload_timer_bench.sv
module cap_reload_timer_bench;
  logic       clk = 1'b0;
  logic       rst_n, reg_wr, tick_en, count_pin, trig_pin;
  logic [2:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic       irq, rx_baud_pulse, tx_baud_pulse;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  cap_reload_timer u_cap_reload_timer (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tick_en(tick_en),
    .count_pin(count_pin), .trig_pin(trig_pin), .irq(irq),
    .rx_baud_pulse(rx_baud_pulse), .tx_baud_pulse(tx_baud_pulse)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic set16(input logic [2:0] base, input logic [15:0] v);
    wr(base, v[7:0]);
    wr(base + 3'd1, v[15:8]);
  endtask

  task automatic get16(input logic [2:0] base, output logic [15:0] v);
    logic [7:0] lo, hi;
    rd(base, lo);
    rd(base + 3'd1, hi);
    v = {hi, lo};
  endtask

  task automatic trig_fall_pulse();
    trig_pin = 1'b0;
    repeat (4) @(negedge clk);
    trig_pin = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic report();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  initial begin
    logic [7:0]  b8;
    logic [15:0] v16, expv;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    tick_en = 1'b0; count_pin = 1'b1; trig_pin = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), b8);
      check("R1 reg", b8, 0);
    end
    check("R1 irq", irq, 0);
    check("R1 pulses", {rx_baud_pulse, tx_baud_pulse}, 0);

    // R2 register map readback
    for (int a = 1; a < 5; a++) begin
      wr(3'(a), 8'hA0 + 8'(a));
      rd(3'(a), b8);
      check("R2 data reg", b8, 8'hA0 + a);
    end
    wr(0, 8'h0B);
    rd(0, b8);
    check("R2 ctrl", b8, 8'h0B);
    for (int a = 5; a < 8; a++) begin
      rd(3'(a), b8);
      check("R2 unused", b8, 0);
    end
    wr(0, 8'h00);

    // R3 timer counting with several tick duty patterns
    for (int p = 1; p <= 3; p++) begin
      int n;
      n = 0;
      set16(1, 16'h0000);
      wr(0, 8'h04);
      for (int i = 0; i < 24; i++) begin
        tick_en = (i % (p + 1)) != 0;
        if (tick_en) n++;
        @(negedge clk);
      end
      tick_en = 1'b0;
      wr(0, 8'h00);
      get16(1, v16);
      check("R3 count", v16, n);
      tick_en = 1'b1;
      repeat (10) @(negedge clk);
      tick_en = 1'b0;
      get16(1, v16);
      check("R3 hold", v16, n);
    end

    // R4 count-pin mode, tick ignored
    set16(1, 16'h0000);
    wr(0, 8'h06);
    tick_en = 1'b1;
    for (int k = 0; k < 7; k++) begin
      count_pin = 1'b0; repeat (2) @(negedge clk);
      count_pin = 1'b1; repeat (2) @(negedge clk);
    end
    repeat (6) @(negedge clk);
    get16(1, v16);
    check("R4 pin count", v16, 7);
    tick_en = 1'b0;
    wr(0, 8'h00);

    // R5 overflow in capture mode wraps to zero, sets flag (R12 irq)
    set16(1, 16'hFFFD);
    wr(0, 8'h05);
    tick_en = 1'b1; repeat (3) @(negedge clk); tick_en = 1'b0;
    get16(1, v16);
    check("R5 wrap zero", v16, 0);
    rd(0, b8);
    check("R5 ovf flag", b8, 8'h85);
    check("R12 irq ovf", irq, 1);
    wr(0, 8'h00);
    rd(0, b8);
    check("R6 clear", b8, 8'h00);
    check("R12 irq low", irq, 0);

    // R5 overflow in reload mode
    set16(3, 16'h1234);
    set16(1, 16'hFFFE);
    wr(0, 8'h04);
    tick_en = 1'b1; repeat (3) @(negedge clk); tick_en = 1'b0;
    get16(1, v16);
    check("R5 reload", v16, 16'h1235);
    rd(0, b8);
    check("R5 reload flag", b8, 8'h84);
    wr(0, 8'h00);

    // R6 hardware set wins over same-cycle software clear
    set16(1, 16'hFFFF);
    wr(0, 8'h05);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 8'h05; tick_en = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; tick_en = 1'b0;
    rd(0, b8);
    check("R6 set priority", b8, 8'h85);
    repeat (3) @(negedge clk);
    rd(0, b8);
    check("R6 sticky", b8, 8'h85);
    wr(0, 8'h00);

    // R7 capture sweep
    for (int k = 0; k < 6; k++) begin
      expv = 16'h0ABC + 16'(k * 16'h1111);
      set16(1, expv);
      wr(0, 8'h09);
      trig_fall_pulse();
      get16(3, v16);
      check("R7 capture", v16, expv);
      rd(0, b8);
      check("R7 trg flag", b8, 8'h49);
      check("R12 irq trg", irq, 1);
    end
    wr(0, 8'h00);

    // R8 reload on trigger
    set16(3, 16'h5555);
    set16(1, 16'h0010);
    wr(0, 8'h08);
    trig_fall_pulse();
    get16(1, v16);
    check("R8 trig reload", v16, 16'h5555);
    rd(0, b8);
    check("R8 trg flag", b8, 8'h48);

    // R9 trigger disabled, both capture and reload settings
    for (int m = 0; m < 2; m++) begin
      set16(1, 16'h7777);
      set16(3, 16'h1111);
      wr(0, 8'(m));
      trig_fall_pulse();
      get16(1, v16);
      check("R9 count kept", v16, 16'h7777);
      get16(3, v16);
      check("R9 cap kept", v16, 16'h1111);
      rd(0, b8);
      check("R9 no flag", b8, m);
    end

    // R10 baud mode: trigger ignored, forced reload, no ovf flag
    set16(3, 16'h8000);
    set16(1, 16'hFFFF);
    wr(0, 8'h29);
    trig_fall_pulse();
    get16(3, v16);
    check("R10 trig ignored", v16, 16'h8000);
    rd(0, b8);
    check("R10 no trg flag", b8, 8'h29);
    wr(0, 8'h2D);
    tick_en = 1'b1; @(negedge clk); tick_en = 1'b0;
    get16(1, v16);
    check("R10 forced reload", v16, 16'h8000);
    rd(0, b8);
    check("R10 no ovf flag", b8, 8'h2D);
    wr(0, 8'h00);

    // R11 baud period sweep for both directions
    for (int dir = 0; dir < 2; dir++) begin
      for (int p = 1; p <= 8; p++) begin
        int on_cnt, off_cnt, first;
        on_cnt = 0; off_cnt = 0; first = 0;
        set16(3, 16'(65536 - p));
        set16(1, 16'(65536 - p));
        wr(0, dir == 0 ? 8'h24 : 8'h14);
        tick_en = 1'b1;
        for (int i = 1; i <= 4 * p; i++) begin
          @(negedge clk);
          if ((dir == 0 ? rx_baud_pulse : tx_baud_pulse) === 1'b1) begin
            on_cnt++;
            if (first == 0) first = i;
          end
          if ((dir == 0 ? tx_baud_pulse : rx_baud_pulse) === 1'b1) off_cnt++;
        end
        tick_en = 1'b0;
        check("R11 pulse count", on_cnt, 4);
        check("R11 first pulse", first, p);
        check("R11 other dir", off_cnt, 0);
        wr(0, 8'h00);
        get16(1, v16);
        check("R11 count reloaded", v16, 65536 - p);
      end
    end

    done = 1'b1;
    report();
  end
endmodule